// File: doc/BRIEF.md
# Handshake Channel Protocol Monitor

A passive observer for one point-to-point channel that moves packets under a two-signal handshake: the sender raises a valid strobe with data, and the receiver raises a ready strobe. Every cycle the monitor labels the channel with one of four handshake conditions. It drives nothing on the channel; it only raises flags and keeps counts.

Four checks run side by side. The first is a retry-persistence rule: a one-sided wait must hold until a transfer happens. The second requires the data to stay put while the sender waits. The third is a bounded watchdog that stands in for deadlock: it fires when a packet has been offered for too many consecutive cycles without being taken. The fourth is a programmable masked-compare predicate that every offered packet must satisfy. Each error flag is sticky until a synchronous clear. Two wrapping counters track transfers and one-sided wait cycles for coarse profiling.

Top module: `chan_hs_monitor`

## Requirements
- R1: `state_o` equals {valid, ready} each cycle, with no register in between: 2'b00 idle, 2'b01 receiver waiting, 2'b10 sender waiting, 2'b11 transfer.
- R2: After a 2'b10 cycle the next cycle must be 2'b10 or 2'b11. After a 2'b01 cycle the next cycle must be 2'b01 or 2'b11. Any other successor sets `err_retry_o` at the closing edge of that successor cycle. The cycle that comes before the first cycle after reset counts as 2'b00.
- R3: If the previous cycle was 2'b10, valid is high in the current cycle and the data differs from the previous cycle's data, `err_stable_o` is set.
- R4: A run counter counts consecutive 2'b10 cycles, including the current one. When this count reaches a nonzero `stall_limit_i`, `err_dead_o` is set at the closing edge of that cycle. A limit of 0 turns the watchdog off. Any cycle other than 2'b10 restarts the count.
- R5: A cycle with valid high and (data AND `prop_mask_i`) not equal to `prop_value_i` sets `err_prop_o`. A cycle with valid low never sets it.
- R6: Every error flag stays set until a cycle with `clr_i` high. That cycle zeroes all flags and both counters and discards any error or count it would otherwise have produced.
- R7: `xfer_cnt_o` increments once per 2'b11 cycle and wraps modulo 2^CNT_W.
- R8: `retry_cnt_o` increments once per 2'b10 or 2'b01 cycle, holds on 2'b00 and 2'b11 cycles, and wraps modulo 2^CNT_W.
- R9: While `rst` is high at an edge, all flags and both counters become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of flags and counters |
| ch_valid_i | input | 1 | Sender-ready strobe of the observed channel |
| ch_ready_i | input | 1 | Receiver-ready strobe of the observed channel |
| ch_data_i | input | DATA_W | Data of the observed channel |
| stall_limit_i | input | STALL_W | Watchdog limit in cycles, 0 = off |
| prop_mask_i | input | DATA_W | Mask applied to data before the compare |
| prop_value_i | input | DATA_W | Expected masked data value |
| state_o | output | 2 | Current handshake condition |
| err_retry_o | output | 1 | Sticky retry-persistence breach |
| err_stable_o | output | 1 | Sticky data change while waiting |
| err_dead_o | output | 1 | Sticky watchdog expiry |
| err_prop_o | output | 1 | Sticky predicate failure |
| xfer_cnt_o | output | CNT_W | Transfer count |
| retry_cnt_o | output | CNT_W | One-sided wait cycle count |

## Verification
The bench builds the monitor with an 8-bit data path, a 4-bit stall limit and 8-bit counters. With these widths it can sweep all sixteen previous/current handshake pairs and every watchdog limit from 1 to 15. It can also offer all 256 data values against the predicate. The narrow counters make wraparound reachable within a few hundred transfers, and a stall run longer than the counter's top value shows that saturation keeps the watchdog flag firing.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
    // encoding is {valid, ready}
    typedef enum logic [1:0] {
        HS_IDLE = 2'b00,
        HS_RXW  = 2'b01,
        HS_TXW  = 2'b10,
        HS_XFER = 2'b11
    } hs_state_e;
endpackage

// File: rtl/hs_classify.sv
module hs_classify
    import hs_mon_pkg::*;
(
    input  logic      valid_i,
    input  logic      ready_i,
    output hs_state_e state_o
);
    always_comb begin
        unique case ({valid_i, ready_i})
            2'b00:   state_o = HS_IDLE;
            2'b01:   state_o = HS_RXW;
            2'b10:   state_o = HS_TXW;
            default: state_o = HS_XFER;
        endcase
    end
endmodule

// File: rtl/hs_stall_timer.sv
module hs_stall_timer #(
    parameter int STALL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               waiting_i,
    input  logic [STALL_W-1:0] limit_i,
    output logic               hit_o
);
    localparam logic [STALL_W-1:0] RUN_MAX = {STALL_W{1'b1}};

    logic [STALL_W-1:0] run_d, run_q;

    always_comb begin
        if (!waiting_i)
            run_d = '0;
        else if (run_q == RUN_MAX)
            run_d = RUN_MAX;
        else
            run_d = run_q + STALL_W'(1);
        hit_o = waiting_i && (limit_i != '0) && (run_d >= limit_i);
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end
endmodule

// File: rtl/hs_event_counter.sv
module hs_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/chan_hs_monitor.sv
module chan_hs_monitor
    import hs_mon_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int STALL_W = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               ch_valid_i,
    input  logic               ch_ready_i,
    input  logic [DATA_W-1:0]  ch_data_i,
    input  logic [STALL_W-1:0] stall_limit_i,
    input  logic [DATA_W-1:0]  prop_mask_i,
    input  logic [DATA_W-1:0]  prop_value_i,
    output logic [1:0]         state_o,
    output logic               err_retry_o,
    output logic               err_stable_o,
    output logic               err_dead_o,
    output logic               err_prop_o,
    output logic [CNT_W-1:0]   xfer_cnt_o,
    output logic [CNT_W-1:0]   retry_cnt_o
);
    typedef struct packed {
        hs_state_e         prev;
        logic [DATA_W-1:0] data;
        logic              e_retry;
        logic              e_stable;
        logic              e_dead;
        logic              e_prop;
    } mon_reg_t;

    mon_reg_t  r_d, r_q;
    hs_state_e cur;
    logic      stall_hit;
    logic      bad_retry, bad_stable, bad_prop;

    hs_classify u_cls (
        .valid_i (ch_valid_i),
        .ready_i (ch_ready_i),
        .state_o (cur)
    );

    hs_stall_timer #(.STALL_W(STALL_W)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .waiting_i (cur == HS_TXW),
        .limit_i   (stall_limit_i),
        .hit_o     (stall_hit)
    );

    hs_event_counter #(.CNT_W(CNT_W)) u_xfer_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .inc_i (cur == HS_XFER),
        .cnt_o (xfer_cnt_o)
    );

    hs_event_counter #(.CNT_W(CNT_W)) u_retry_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .inc_i ((cur == HS_TXW) || (cur == HS_RXW)),
        .cnt_o (retry_cnt_o)
    );

    always_comb begin
        bad_retry = 1'b0;
        case (r_q.prev)
            HS_TXW:  bad_retry = (cur != HS_TXW) && (cur != HS_XFER);
            HS_RXW:  bad_retry = (cur != HS_RXW) && (cur != HS_XFER);
            default: bad_retry = 1'b0;
        endcase
        bad_stable = (r_q.prev == HS_TXW) && ch_valid_i && (ch_data_i != r_q.data);
        bad_prop   = ch_valid_i && ((ch_data_i & prop_mask_i) != prop_value_i);

        r_d      = r_q;
        r_d.prev = cur;
        r_d.data = ch_data_i;
        if (clr_i) begin
            r_d.e_retry  = 1'b0;
            r_d.e_stable = 1'b0;
            r_d.e_dead   = 1'b0;
            r_d.e_prop   = 1'b0;
        end else begin
            r_d.e_retry  = r_q.e_retry  | bad_retry;
            r_d.e_stable = r_q.e_stable | bad_stable;
            r_d.e_dead   = r_q.e_dead   | stall_hit;
            r_d.e_prop   = r_q.e_prop   | bad_prop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.prev     <= HS_IDLE;
            r_q.data     <= '0;
            r_q.e_retry  <= 1'b0;
            r_q.e_stable <= 1'b0;
            r_q.e_dead   <= 1'b0;
            r_q.e_prop   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o      = cur;
    assign err_retry_o  = r_q.e_retry;
    assign err_stable_o = r_q.e_stable;
    assign err_dead_o   = r_q.e_dead;
    assign err_prop_o   = r_q.e_prop;
endmodule

// File: rtl/hs_mon_checker.sv
module hs_mon_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_i,
    input logic              ch_valid_i,
    input logic              ch_ready_i,
    input logic              err_retry_o,
    input logic              err_stable_o,
    input logic              err_dead_o,
    input logic              err_prop_o,
    input logic [CNT_W-1:0]  xfer_cnt_o,
    input logic [CNT_W-1:0]  retry_cnt_o
);
    logic [3:0] flags;
    assign flags = {err_retry_o, err_stable_o, err_dead_o, err_prop_o};

    // R2: sender withdraws without a transfer
    a_r2_tx_withdraw: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ch_valid_i && !ch_ready_i) && !ch_valid_i && !clr_i)
        |=> err_retry_o);

    // R5: an idle sender never raises the predicate flag
    a_r5_no_prop_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !ch_valid_i) |=> !$rose(err_prop_o));

    // R6: flags never drop without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((flags & $past(flags)) == $past(flags)));

    // R6: clear empties flags and counters
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (flags == 4'b0 && xfer_cnt_o == '0 && retry_cnt_o == '0));

    // R7: each transfer adds one
    a_r7_xfer_step: assert property (@(posedge clk) disable iff (rst)
        (ch_valid_i && ch_ready_i && !clr_i)
        |=> (xfer_cnt_o == $past(xfer_cnt_o) + CNT_W'(1)));

    // R8: wait counter holds on two-sided conditions
    a_r8_retry_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && (ch_valid_i == ch_ready_i)) |=> $stable(retry_cnt_o));

    // R9: reset empties flags and counters
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (flags == 4'b0 && xfer_cnt_o == '0 && retry_cnt_o == '0));
endmodule

bind chan_hs_monitor hs_mon_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (clr_i),
    .ch_valid_i   (ch_valid_i),
    .ch_ready_i   (ch_ready_i),
    .err_retry_o  (err_retry_o),
    .err_stable_o (err_stable_o),
    .err_dead_o   (err_dead_o),
    .err_prop_o   (err_prop_o),
    .xfer_cnt_o   (xfer_cnt_o),
    .retry_cnt_o  (retry_cnt_o)
);

// File: tb/chan_hs_monitor_tb_top.sv
`timescale 1ns/1ps
module chan_hs_monitor_tb_top;
    localparam int DW = 8;
    localparam int SW = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          vld = 1'b0;
    logic          rdy = 1'b0;
    logic [DW-1:0] dat = '0;
    logic [SW-1:0] lim = '0;
    logic [DW-1:0] msk = '0;
    logic [DW-1:0] val = '0;
    logic [1:0]    st;
    logic          e_rt, e_sb, e_dd, e_pr;
    logic [CW-1:0] xc, rc;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    chan_hs_monitor #(.DATA_W(DW), .STALL_W(SW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .clr_i(clr), .ch_valid_i(vld), .ch_ready_i(rdy),
        .ch_data_i(dat), .stall_limit_i(lim), .prop_mask_i(msk), .prop_value_i(val),
        .state_o(st), .err_retry_o(e_rt), .err_stable_o(e_sb), .err_dead_o(e_dd),
        .err_prop_o(e_pr), .xfer_cnt_o(xc), .retry_cnt_o(rc)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs are read 1 ns after the closing edge
    task automatic cyc(input logic v, input logic r, input logic [DW-1:0] d, input logic c);
        vld = v; rdy = r; dat = d; clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic clear();
        cyc(1'b0, 1'b0, '0, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset values
        chk("R9 flags", {e_rt, e_sb, e_dd, e_pr}, 0);
        chk("R9 xfer", xc, 0);
        chk("R9 retry", rc, 0);
        rst = 1'b0;

        // R1: combinational classification
        for (int s = 0; s < 4; s++) begin
            vld = s[1]; rdy = s[0];
            #0.5;
            chk("R1 state", st, s);
        end
        clear();

        // legal sequence: counts, no errors (R7, R8)
        cyc(1, 0, 8'h11, 0); cyc(1, 0, 8'h11, 0); cyc(1, 1, 8'h11, 0);
        cyc(0, 1, 8'h22, 0); cyc(0, 1, 8'h33, 0); cyc(1, 1, 8'h44, 0);
        cyc(0, 0, 8'h55, 0);
        chk("R2 legal seq", e_rt, 0);
        chk("R3 legal seq", e_sb, 0);
        chk("R7 xfer count", xc, 2);
        chk("R8 retry count", rc, 4);

        // R2: all previous/current pairs
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                bit exp_bad;
                clear();
                cyc(p[1], p[0], 8'h5A, 0);
                cyc(n[1], n[0], 8'h5A, 0);
                exp_bad = (p == 2 && !(n == 2 || n == 3)) || (p == 1 && !(n == 1 || n == 3));
                chk($sformatf("R2 pair %0d->%0d", p, n), e_rt, exp_bad);
                chk("R3 no change", e_sb, 0);
            end
        end

        // R3: data stability while sender waits
        clear(); cyc(1, 0, 8'hA1, 0); cyc(1, 0, 8'hA2, 0);
        chk("R3 change in wait", e_sb, 1);
        clear(); cyc(1, 0, 8'hA1, 0); cyc(1, 1, 8'hB2, 0);
        chk("R3 change at transfer", e_sb, 1);
        clear(); cyc(1, 0, 8'hA1, 0); cyc(1, 0, 8'hA1, 0); cyc(1, 1, 8'hA1, 0);
        chk("R3 stable wait", e_sb, 0);
        clear(); cyc(0, 1, 8'h01, 0); cyc(0, 1, 8'h02, 0); cyc(0, 0, 8'h03, 0);
        cyc(1, 1, 8'h04, 0); cyc(1, 1, 8'h05, 0);
        chk("R3 free change", e_sb, 0);

        // R4: watchdog limits 1..15
        for (int l = 1; l < 16; l++) begin
            lim = SW'(l);
            clear();
            for (int k = 0; k < l - 1; k++) cyc(1, 0, 8'h0F, 0);
            chk($sformatf("R4 below limit %0d", l), e_dd, 0);
            cyc(1, 0, 8'h0F, 0);
            chk($sformatf("R4 at limit %0d", l), e_dd, 1);
            cyc(1, 1, 8'h0F, 0);
        end
        // R4: a transfer restarts the run
        lim = 4'd3;
        clear();
        cyc(1, 0, 8'h0F, 0); cyc(1, 0, 8'h0F, 0); cyc(1, 1, 8'h0F, 0);
        cyc(1, 0, 8'h0F, 0); cyc(1, 0, 8'h0F, 0);
        chk("R4 run restart", e_dd, 0);
        cyc(1, 1, 8'h0F, 0);
        // R4: limit 0 disables, long run past saturation with limit 15
        lim = 4'd0;
        clear();
        for (int k = 0; k < 20; k++) cyc(1, 0, 8'h0F, 0);
        chk("R4 limit zero", e_dd, 0);
        lim = 4'd15;
        cyc(1, 0, 8'h0F, 0);
        chk("R4 saturated run", e_dd, 1);
        cyc(1, 1, 8'h0F, 0);
        lim = 4'd0;

        // R5: predicate sweep over all data values
        msk = 8'hF0; val = 8'hA0;
        for (int d = 0; d < 256; d++) begin
            clear();
            cyc(1, 1, DW'(d), 0);
            chk($sformatf("R5 data %0d", d), e_pr, ((d & 8'hF0) != 8'hA0) ? 1 : 0);
        end
        clear();
        cyc(0, 0, 8'h00, 0); cyc(0, 1, 8'h13, 0);
        chk("R5 valid low", e_pr, 0);

        // R6: sticky and clear priority
        clear(); cyc(1, 1, 8'h00, 0);
        cyc(1, 1, 8'hA5, 0); cyc(0, 0, 8'hA5, 0);
        chk("R6 sticky", e_pr, 1);
        cyc(1, 1, 8'h00, 1);
        chk("R6 clear wins flag", e_pr, 0);
        chk("R6 clear wins count", xc, 0);
        msk = '0; val = '0;

        // R7 and R8: wraparound
        clear();
        for (int k = 0; k < 257; k++) cyc(1, 1, 8'h00, 0);
        chk("R7 wrap", xc, 1);
        for (int k = 0; k < 258; k++) cyc(0, 1, 8'h00, 0);
        chk("R8 wrap", rc, 2);
        cyc(0, 0, 8'h00, 0); cyc(1, 1, 8'h00, 0);
        chk("R8 hold", rc, 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule